// File: doc/BRIEF.md
# Automatic Maintenance Command Processor

This block answers maintenance commands on the network-terminal side of a subscriber line. Each input message has already passed a triple-match validator, and it arrives as a three-bit address and an eight-bit command code with a one-cycle valid strobe. The block checks the address and decodes the command. It latches the loopback and error-injection controls that the command invokes, and it builds the reply to send back toward the line. It also forwards every qualified message to the host-facing message register.

Invoked functions stay latched until one of these events: a return-to-normal command, loss of link, selection of line-side operation, or reset. A command with a recognised code is echoed back, carrying the terminal address. A command addressed to some other terminal gets a hold reply, and the latched state does not change. In line-side mode the processor is inactive, so only the host forwarding remains, which is plain triple-match behaviour. The data-path loopback switching is not part of this block.

Top module: `maint_cmd_proc`

## Requirements
- R1: While reset is asserted, all outputs are 0.
- R2: A command is addressed when its address is 0 (terminal) or 7 (broadcast). Any other address produces response code 0x00 (hold) with response address 0, and the latched functions do not change.
- R3: An addressed code 0x50 sets `loop_2bd`. It also sets `loop_2bd_transp` to the value that `cfg_loop_transp` has in the cycle of the command.
- R4: An addressed code 0x51 sets `loop_b1`, and an addressed code 0x52 sets `loop_b2`. Both of these loopbacks are transparent.
- R5: An addressed code 0x53 sets `crc_corrupt_req`. Addressed codes 0x54 (notify) and 0x00 (hold) leave every latched function unchanged.
- R6: An addressed code 0xFF clears every latched function.
- R7: An addressed command with a recognised code (0x00, 0x50 to 0x54, 0xFF) is echoed in `rsp_code`. An addressed command with any other code gets 0xAA (unable to comply). `rsp_addr` is always 0.
- R8: `rsp_valid` pulses exactly one cycle after an accepted strobe, that is, `msg_valid` with `link_up` high and `line_side` low. `host_load` pulses one cycle after any strobe seen with `link_up` high, and `host_addr` and `host_code` then carry the received message.
- R9: While `line_side` is high, no response is produced and all latched functions are cleared. Host forwarding still operates.
- R10: While `link_up` is low, all latched functions clear and no strobe is acted on, including host forwarding.
- R11: Invoked functions accumulate: setting one does not clear another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_side | input | 1 | 1 selects line-side operation (processor inactive) |
| link_up | input | 1 | Link and superframe sync both present |
| cfg_loop_transp | input | 1 | Transparency setting for the 2B+D loopback |
| msg_valid | input | 1 | Validated message strobe |
| msg_addr | input | 3 | Message address |
| msg_code | input | 8 | Message command code |
| loop_2bd | output | 1 | 2B+D loopback enable |
| loop_2bd_transp | output | 1 | 2B+D loopback transparency |
| loop_b1 | output | 1 | B1 loopback enable |
| loop_b2 | output | 1 | B2 loopback enable |
| crc_corrupt_req | output | 1 | Corrupt-CRC request |
| rsp_valid | output | 1 | Response word strobe |
| rsp_addr | output | 3 | Response address |
| rsp_code | output | 8 | Response code |
| host_load | output | 1 | Host register load strobe |
| host_addr | output | 3 | Forwarded address |
| host_code | output | 8 | Forwarded code |

## Verification
Every result is registered once. The latched controls, the response word and the host forwarding all take effect at the first rising edge after the strobe. Clearing on loss of link or in line-side mode also takes effect at that same edge. The bench drives a strobe on a falling edge and keeps it through the next rising edge. At the falling edge that follows, it compares all outputs with its own model, which it advances by exactly one step per cycle. It compares response and host fields only in cycles where its model predicts a pulse, because those fields hold their values between pulses.

// File: rtl/maint_pkg.sv
package maint_pkg;
  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] C_HOLD   = 8'h00;
  localparam logic [CODE_W-1:0] C_LP_2BD = 8'h50;
  localparam logic [CODE_W-1:0] C_LP_B1  = 8'h51;
  localparam logic [CODE_W-1:0] C_LP_B2  = 8'h52;
  localparam logic [CODE_W-1:0] C_CRC_RQ = 8'h53;
  localparam logic [CODE_W-1:0] C_CRC_NT = 8'h54;
  localparam logic [CODE_W-1:0] C_NORMAL = 8'hFF;
  localparam logic [CODE_W-1:0] C_UTC    = 8'hAA;

  // bit index of each latched function in the set vector
  localparam int F_2BD = 0;
  localparam int F_B1  = 1;
  localparam int F_B2  = 2;
  localparam int F_CRC = 3;
  localparam int NUM_F = 4;

  typedef struct packed {
    logic             known;
    logic             clr;
    logic [NUM_F-1:0] set;
  } cmd_act_t;

  function automatic cmd_act_t decode_cmd(input logic [CODE_W-1:0] code);
    cmd_act_t a;
    a = '0;
    unique case (code)
      C_LP_2BD: begin a.known = 1'b1; a.set[F_2BD] = 1'b1; end
      C_LP_B1:  begin a.known = 1'b1; a.set[F_B1]  = 1'b1; end
      C_LP_B2:  begin a.known = 1'b1; a.set[F_B2]  = 1'b1; end
      C_CRC_RQ: begin a.known = 1'b1; a.set[F_CRC] = 1'b1; end
      C_CRC_NT: a.known = 1'b1;
      C_HOLD:   a.known = 1'b1;
      C_NORMAL: begin a.known = 1'b1; a.clr = 1'b1; end
      default:  a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [CODE_W-1:0] reply_code(input logic hit, input logic known,
                                                   input logic [CODE_W-1:0] code);
    if (!hit)       return C_HOLD;
    else if (known) return code;
    else            return C_UTC;
  endfunction
endpackage

// File: rtl/mcp_addr_filter.sv
module mcp_addr_filter #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] TERM_ADDR  = '0,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  always_comb hit = (addr == TERM_ADDR) || (addr == BCAST_ADDR);
endmodule

// File: rtl/mcp_cmd_decode.sv
module mcp_cmd_decode
  import maint_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output cmd_act_t          act
);
  always_comb act = decode_cmd(code);
endmodule

// File: rtl/mcp_func_latch.sv
module mcp_func_latch
  import maint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic [NUM_F-1:0] set_vec,
  input  logic             cfg_transp,
  output logic [NUM_F-1:0] func_q,
  output logic             transp_q
);
  for (genvar i = 0; i < NUM_F; i++) begin : g_fn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          func_q[i] <= 1'b0;
      else if (clr_all)    func_q[i] <= 1'b0;
      else if (set_vec[i]) func_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              transp_q <= 1'b0;
    else if (clr_all)        transp_q <= 1'b0;
    else if (set_vec[F_2BD]) transp_q <= cfg_transp;
  end
endmodule

// File: rtl/mcp_resp_gen.sv
module mcp_resp_gen
  import maint_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] TERM_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              hit,
  input  logic              known,
  input  logic [CODE_W-1:0] code,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [CODE_W-1:0] rsp_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_code  <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_addr <= TERM_ADDR;
        rsp_code <= reply_code(hit, known, code);
      end
    end
  end
endmodule

// File: rtl/maint_cmd_proc.sv
module maint_cmd_proc
  import maint_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] TERM_ADDR  = '0,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_side,
  input  logic              link_up,
  input  logic              cfg_loop_transp,
  input  logic              msg_valid,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [CODE_W-1:0] msg_code,
  output logic              loop_2bd,
  output logic              loop_2bd_transp,
  output logic              loop_b1,
  output logic              loop_b2,
  output logic              crc_corrupt_req,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [CODE_W-1:0] rsp_code,
  output logic              host_load,
  output logic [ADDR_W-1:0] host_addr,
  output logic [CODE_W-1:0] host_code
);
  // named internal events, visible to the checker
  logic             addr_hit;
  logic             cmd_fire;
  logic             host_fire;
  logic             cmd_upd;
  logic             clr_all;
  cmd_act_t         act;
  logic [NUM_F-1:0] set_vec;
  logic [NUM_F-1:0] func_q;

  mcp_addr_filter #(.ADDR_W(ADDR_W), .TERM_ADDR(TERM_ADDR), .BCAST_ADDR(BCAST_ADDR))
    u_filt (.addr(msg_addr), .hit(addr_hit));

  mcp_cmd_decode u_dec (.code(msg_code), .act(act));

  always_comb begin
    host_fire = msg_valid && link_up;
    cmd_fire  = host_fire && !line_side;
    cmd_upd   = cmd_fire && addr_hit;
    clr_all   = !link_up || line_side || (cmd_upd && act.clr);
    set_vec   = cmd_upd ? act.set : '0;
  end

  mcp_func_latch u_lat (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .set_vec(set_vec),
    .cfg_transp(cfg_loop_transp), .func_q(func_q), .transp_q(loop_2bd_transp)
  );

  mcp_resp_gen #(.ADDR_W(ADDR_W), .TERM_ADDR(TERM_ADDR)) u_rsp (
    .clk(clk), .rst_n(rst_n), .fire(cmd_fire), .hit(addr_hit), .known(act.known),
    .code(msg_code), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_code(rsp_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_load <= 1'b0;
      host_addr <= '0;
      host_code <= '0;
    end else begin
      host_load <= host_fire;
      if (host_fire) begin
        host_addr <= msg_addr;
        host_code <= msg_code;
      end
    end
  end

  always_comb begin
    loop_2bd        = func_q[F_2BD];
    loop_b1         = func_q[F_B1];
    loop_b2         = func_q[F_B2];
    crc_corrupt_req = func_q[F_CRC];
  end
endmodule

// File: rtl/maint_cmd_proc_chk.sv
module maint_cmd_proc_chk #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] TERM_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_side,
  input logic              link_up,
  input logic              msg_valid,
  input logic [ADDR_W-1:0] msg_addr,
  input logic [7:0]        msg_code,
  input logic              addr_hit,
  input logic              loop_2bd,
  input logic              loop_b1,
  input logic              loop_b2,
  input logic              crc_corrupt_req,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [7:0]        rsp_code,
  input logic              host_load,
  input logic [7:0]        host_code
);
  logic [3:0] fn;
  assign fn = {crc_corrupt_req, loop_b2, loop_b1, loop_2bd};

  a_r2_hold_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && link_up && !line_side && !addr_hit) |=> (rsp_code == 8'h00 && $stable(fn)));

  a_r6_normal_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && link_up && !line_side && addr_hit && msg_code == 8'hFF) |=> (fn == 4'b0));

  a_r7_rsp_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_addr == TERM_ADDR));

  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && link_up && !line_side) |=> rsp_valid);

  a_r8_host_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && link_up) |=> (host_load && host_code == $past(msg_code)));

  a_r9_line_side_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    line_side |=> (!rsp_valid && fn == 4'b0));

  a_r10_link_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (fn == 4'b0 && !host_load && !rsp_valid));

  a_r5_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && link_up && !line_side && addr_hit && (msg_code == 8'h54 || msg_code == 8'h00))
      |=> $stable(fn));

  a_r1_reset: assert property (@(posedge clk) !rst_n |-> (fn == 4'b0 && !rsp_valid && !host_load));
endmodule

bind maint_cmd_proc maint_cmd_proc_chk #(.ADDR_W(ADDR_W), .TERM_ADDR(TERM_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_side(line_side), .link_up(link_up),
  .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_code(msg_code), .addr_hit(addr_hit),
  .loop_2bd(loop_2bd), .loop_b1(loop_b1), .loop_b2(loop_b2),
  .crc_corrupt_req(crc_corrupt_req), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
  .rsp_code(rsp_code), .host_load(host_load), .host_code(host_code)
);

// File: tb/maint_cmd_proc_tb.sv
`timescale 1ns/100ps
module maint_cmd_proc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_side = 1'b0, link_up = 1'b0, cfg_loop_transp = 1'b0, msg_valid = 1'b0;
  logic [2:0] msg_addr = '0;
  logic [7:0] msg_code = '0;
  logic loop_2bd, loop_2bd_transp, loop_b1, loop_b2, crc_corrupt_req;
  logic rsp_valid, host_load;
  logic [2:0] rsp_addr, host_addr;
  logic [7:0] rsp_code, host_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state: {crc, b2, b1, 2bd} and transparency
  logic [3:0] m_fn = '0;
  logic       m_tr = 1'b0;

  always #2.5 clk = ~clk;

  maint_cmd_proc u_dut (.*);

  function automatic bit is_hit(input logic [2:0] a);
    return (a == 3'd0) || (a == 3'd7);
  endfunction

  function automatic bit is_known(input logic [7:0] c);
    return (c == 8'h00) || (c == 8'hFF) || (c >= 8'h50 && c <= 8'h54);
  endfunction

  function automatic logic [7:0] exp_reply(input logic [2:0] a, input logic [7:0] c);
    if (!is_hit(a)) return 8'h00;
    return is_known(c) ? c : 8'hAA;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // drive one cycle on a falling edge, check at the next falling edge
  task automatic step(input bit v, input logic [2:0] a, input logic [7:0] c,
                      input bit lu, input bit ls, input bit tr);
    bit hf, cf;
    msg_valid = v; msg_addr = a; msg_code = c;
    link_up = lu; line_side = ls; cfg_loop_transp = tr;
    hf = v && lu;
    cf = hf && !ls;
    if (!lu || ls) begin
      m_fn = '0; m_tr = 1'b0;
    end else if (cf && is_hit(a)) begin
      case (c)
        8'hFF: begin m_fn = '0; m_tr = 1'b0; end
        8'h50: begin m_fn[0] = 1'b1; m_tr = tr; end
        8'h51: m_fn[1] = 1'b1;
        8'h52: m_fn[2] = 1'b1;
        8'h53: m_fn[3] = 1'b1;
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R3/R4/R5/R6/R11 functions", {crc_corrupt_req, loop_b2, loop_b1, loop_2bd}, m_fn);
    chk("R3 transparency", loop_2bd_transp, m_tr);
    chk("R8/R9/R10 rsp_valid", rsp_valid, cf);
    chk("R8/R10 host_load", host_load, hf);
    if (cf) begin
      chk("R2/R7 rsp_code", rsp_code, exp_reply(a, c));
      chk("R7 rsp_addr", rsp_addr, 3'd0);
    end
    if (hf) begin
      chk("R8 host_code", host_code, c);
      chk("R8 host_addr", host_addr, a);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [0:9];
    pool = '{8'h00, 8'h50, 8'h51, 8'h52, 8'h53, 8'h54, 8'hFF, 8'hAA, 8'h55, 8'h4F};
    void'($urandom(32'd2718));
    // R1: reset state
    msg_valid = 1'b1; link_up = 1'b1; msg_code = 8'h50;
    repeat (3) @(negedge clk);
    chk("R1 functions", {crc_corrupt_req, loop_b2, loop_b1, loop_2bd, loop_2bd_transp}, 5'b0);
    chk("R1 strobes", {rsp_valid, host_load}, 2'b0);
    chk("R1 words", {rsp_addr, rsp_code, host_addr, host_code}, 22'b0);
    msg_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // directed cases
    step(1, 3'd0, 8'h50, 1, 0, 1);   // R3 with transparency
    step(1, 3'd7, 8'h51, 1, 0, 0);   // R4 broadcast, R11 accumulate
    step(1, 3'd0, 8'h52, 1, 0, 0);   // R4
    step(1, 3'd3, 8'hFF, 1, 0, 0);   // R2 misaddressed, no clear
    step(1, 3'd0, 8'h54, 1, 0, 0);   // R5 notify no effect
    step(1, 3'd0, 8'h00, 1, 0, 0);   // R5 hold no effect
    step(1, 3'd0, 8'h53, 1, 0, 0);   // R5 crc request
    step(1, 3'd0, 8'h99, 1, 0, 0);   // R7 unable to comply
    step(1, 3'd7, 8'hFF, 1, 0, 0);   // R6 clear all
    step(1, 3'd0, 8'h50, 1, 0, 0);   // R3 non-transparent
    step(1, 3'd0, 8'h51, 1, 1, 0);   // R9 line side
    step(1, 3'd0, 8'h51, 1, 0, 0);
    step(1, 3'd0, 8'h52, 0, 0, 0);   // R10 link loss
    step(0, 3'd0, 8'h00, 1, 0, 0);
    // constrained random
    for (int i = 0; i < 600; i++) begin
      bit v, lu, ls, tr;
      logic [2:0] a;
      logic [7:0] c;
      v  = ($urandom % 4) != 0;
      lu = ($urandom % 20) != 0;
      ls = ($urandom % 25) == 0;
      tr = $urandom % 2;
      a  = ($urandom % 3 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'd7 : 3'd0);
      c  = ($urandom % 8 == 0) ? 8'($urandom) : pool[$urandom % 10];
      step(v, a, c, lu, ls, tr);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule